// File: doc/BRIEF.md
# Bitfield insert unit

This unit deposits the low bits of an insert operand into a field of a 32-bit destination word and returns the updated word. The field can have any width from 1 to 32 bits and can start at any bit. The field geometry comes from a 16-bit extension word. That word either holds the width and offset directly, or it redirects each of them to a general register value that is supplied on its own port. The offset counts from the most significant bit. A field that runs past bit 0 continues at bit 31. All destination bits outside the field keep their old values.

With the result the unit also produces condition flags that describe the inserted value. N is the most significant inserted bit. Z is set when every inserted bit is zero. V and C are always cleared.

The operands are sampled on a one-cycle start pulse. The result and flags are registered and appear on the next cycle together with a one-cycle valid strobe. Register selection and writeback are handled by the surrounding datapath.

Top module: `bfins_unit`

## Requirements
- R1: While rst_n is low at a clock edge, result, flag_n, flag_z, flag_v, flag_c and valid all become 0.
- R2: When extension bit 5 is 0, the width is extension bits 4:0. When bit 5 is 1, the width is bits 4:0 of width_reg. In both cases a value of 0 means a width of 32.
- R3: When extension bit 11 is 0, the offset is extension bits 10:6. When bit 11 is 1, the offset is width... the offset is off_reg modulo 32 (its bits 4:0). Extension bits 15:12 have no effect.
- R4: For offset o and width w with o+w ≤ 32, insert bit w-1 lands at result bit 31-o and insert bit 0 lands at result bit 32-o-w.
- R5: Insert operand bits at or above the width have no effect on the result or on the flags.
- R6: When o+w > 32, the field wraps. Insert bit i lands at result bit (32-o-w+i) mod 32, so the upper part of the field ends at bit 0 and the rest continues down from bit 31.
- R7: Every destination bit outside the field appears unchanged in the result.
- R8: A width of 32 replaces the whole word with the insert operand rotated right by the offset.
- R9: flag_n equals insert bit w-1.
- R10: flag_z is 1 exactly when insert bits w-1..0 are all 0.
- R11: flag_v and flag_c are 0 after every operation.
- R12: Result and flags update on the clock edge where start is 1, and valid is 1 in the cycle after. Without start, valid is 0 and result and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle operation request; operands are sampled with it |
| dst_in | input | 32 | Destination word before insertion |
| ins_in | input | 32 | Insert operand; its low width bits are used |
| ext_in | input | 16 | Extension word holding the width, the offset and their register-select bits |
| width_reg | input | 32 | Register value that supplies the width when extension bit 5 is set |
| off_reg | input | 32 | Register value that supplies the offset when extension bit 11 is set |
| result | output | 32 | Updated destination word |
| flag_n | output | 1 | Most significant inserted bit |
| flag_z | output | 1 | All inserted bits are zero |
| flag_v | output | 1 | Overflow flag, always cleared |
| flag_c | output | 1 | Carry flag, always cleared |
| valid | output | 1 | Result and flags were updated on the last edge |

## Verification
The field wrap and the flag evaluation happen in the same cycle. The flags are taken from the shifted insert value and ignore the wrap, so a wrong rotate amount can still produce correct flags.

The bench provokes this with fields where offset plus width exceeds 32, using insert patterns whose top bit is set and whose high garbage bits are non-zero. A behavioural bit-by-bit model checks result and flags on every cycle.

Back-to-back start pulses followed by idle cycles with changing inputs check that a new operation and the holding of the previous one do not interfere.

// File: rtl/bfins_pkg.sv
// Package: shared sizes and types for the bitfield insert unit.
// Assumes DATA_W is a power of two, so the shift amounts fit SH_W bits.
package bfins_pkg;
    localparam int DATA_W = 32;
    localparam int SH_W   = $clog2(DATA_W);
    localparam int EXT_W  = 16;

    // Extension word field positions (the field decoder depends on these)
    localparam int EXT_WID_LSB  = 0;
    localparam int EXT_WID_SEL  = 5;
    localparam int EXT_OFF_LSB  = 6;
    localparam int EXT_OFF_SEL  = 11;

    // Field geometry: width is 1..DATA_W, offset counts from the MSB
    typedef struct packed {
        logic [SH_W:0]   width;
        logic [SH_W-1:0] offset;
    } bf_geom_t;
endpackage

// File: rtl/bfins_field_decode.sv
// Module: picks the field width and offset from the extension word or from
// the register operands. A width code of 0 is widened to DATA_W.
// Assumes the extension layout given in bfins_pkg.
module bfins_field_decode
    import bfins_pkg::*;
(
    input  logic [EXT_W-1:0]  ext_in,
    input  logic [DATA_W-1:0] width_reg,
    input  logic [DATA_W-1:0] off_reg,
    output bf_geom_t          geom
);
    logic [SH_W-1:0] wid_code;

    // Purpose: select the width source and the offset source
    always_comb begin
        if (ext_in[EXT_WID_SEL])
            wid_code = width_reg[SH_W-1:0];
        else
            wid_code = ext_in[EXT_WID_LSB +: SH_W];

        if (ext_in[EXT_OFF_SEL])
            geom.offset = off_reg[SH_W-1:0];
        else
            geom.offset = ext_in[EXT_OFF_LSB +: SH_W];

        if (wid_code == '0)
            geom.width = (SH_W+1)'(DATA_W);
        else
            geom.width = {1'b0, wid_code};
    end
endmodule

// File: rtl/bfins_rotr.sv
// Module: logarithmic barrel rotator, rotates right by amt.
// Assumes W == 2**SW.
module bfins_rotr #(
    parameter int W  = 32,
    parameter int SW = 5
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [0:SW];

    assign stg[0] = din;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        // Purpose: rotate by 2**s when amount bit s is set
        always_comb begin
            if (amt[s])
                stg[s+1] = {stg[s][STEP-1:0], stg[s][W-1:STEP]};
            else
                stg[s+1] = stg[s];
        end
    end

    assign dout = stg[SW];
endmodule

// File: rtl/bfins_place.sv
// Module: merges the masked insert operand into the destination word.
// The low-aligned field is rotated right by (offset+width) mod DATA_W, so a
// field that crosses bit 0 wraps to the top of the word.
// Assumes geom.width is in 1..DATA_W.
module bfins_place
    import bfins_pkg::*;
(
    input  logic [DATA_W-1:0] dst_in,
    input  logic [DATA_W-1:0] ins_in,
    input  bf_geom_t          geom,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] low_mask;
    logic [DATA_W-1:0] low_val;
    logic [DATA_W-1:0] pos_mask;
    logic [DATA_W-1:0] pos_val;
    logic [SH_W:0]     rot_sum;
    logic [SH_W-1:0]   rot_amt;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        // Purpose: mark bit i as a field bit when it lies below the width
        assign low_mask[i] = ((SH_W+1)'(i) < geom.width);
    end

    // Purpose: keep only the used insert bits and form the rotate amount
    always_comb begin
        low_val = ins_in & low_mask;
        rot_sum = geom.width + {1'b0, geom.offset};
        rot_amt = rot_sum[SH_W-1:0];
    end

    bfins_rotr #(.W(DATA_W), .SW(SH_W)) u_rot_mask (
        .din (low_mask),
        .amt (rot_amt),
        .dout(pos_mask)
    );

    bfins_rotr #(.W(DATA_W), .SW(SH_W)) u_rot_val (
        .din (low_val),
        .amt (rot_amt),
        .dout(pos_val)
    );

    // Purpose: clear the field in the destination and drop the new bits in
    assign merged = (dst_in & ~pos_mask) | pos_val;
endmodule

// File: rtl/bfins_flags.sv
// Module: derives N and Z from the insert operand shifted left by
// (DATA_W - width), so that only the used bits remain.
// Assumes width is in 1..DATA_W.
module bfins_flags
    import bfins_pkg::*;
(
    input  logic [DATA_W-1:0] ins_in,
    input  logic [SH_W:0]     width,
    output logic              neg,
    output logic              zero
);
    logic [SH_W:0]     sh_full;
    logic [DATA_W-1:0] aligned;

    // Purpose: left-align the used bits and test them
    always_comb begin
        sh_full = (SH_W+1)'(DATA_W) - width;
        aligned = ins_in << sh_full[SH_W-1:0];
        neg     = aligned[DATA_W-1];
        zero    = (aligned == '0);
    end
endmodule

// File: rtl/bfins_unit.sv
// Module: top of the bitfield insert unit. Decodes the geometry, merges the
// field and computes the flags combinationally, then registers everything
// on a start pulse. Overflow and carry are cleared with every operation.
// Assumes start is at most one request per cycle; reset is synchronous and
// active low.
module bfins_unit
    import bfins_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] dst_in,
    input  logic [DATA_W-1:0] ins_in,
    input  logic [EXT_W-1:0]  ext_in,
    input  logic [DATA_W-1:0] width_reg,
    input  logic [DATA_W-1:0] off_reg,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              valid
);
    bf_geom_t          geom;
    logic [DATA_W-1:0] merged;
    logic              neg_c;
    logic              zero_c;

    bfins_field_decode u_dec (
        .ext_in   (ext_in),
        .width_reg(width_reg),
        .off_reg  (off_reg),
        .geom     (geom)
    );

    bfins_place u_place (
        .dst_in(dst_in),
        .ins_in(ins_in),
        .geom  (geom),
        .merged(merged)
    );

    bfins_flags u_flags (
        .ins_in(ins_in),
        .width (geom.width),
        .neg   (neg_c),
        .zero  (zero_c)
    );

    // Purpose: capture the result and flags on start, hold them otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_v <= 1'b0;
            flag_c <= 1'b0;
            valid  <= 1'b0;
        end else begin
            valid <= start;
            if (start) begin
                result <= merged;
                flag_n <= neg_c;
                flag_z <= zero_c;
                flag_v <= 1'b0;
                flag_c <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/bfins_unit_chk.sv
// Module: property checker for bfins_unit, attached with bind below.
// Observes the ports only.
module bfins_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [31:0] dst_in,
    input logic [31:0] ins_in,
    input logic [15:0] ext_in,
    input logic [31:0] width_reg,
    input logic [31:0] off_reg,
    input logic [31:0] result,
    input logic        flag_n,
    input logic        flag_z,
    input logic        flag_v,
    input logic        flag_c,
    input logic        valid
);
    logic        full_imm;
    logic [63:0] dbl_rot;

    // Purpose: expected word for an immediate full-width insert
    always_comb begin
        full_imm = !ext_in[5] && (ext_in[4:0] == 5'd0) && !ext_in[11];
        dbl_rot  = {ins_in, ins_in} >> ext_in[10:6];
    end

    assert_valid_after_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);

    assert_hold_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!valid && $stable(result) && $stable(flag_n) && $stable(flag_z)));

    assert_full_width_rotate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && full_imm) |=> (result == $past(dbl_rot[31:0])));

    assert_zero_insert_sets_z_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ins_in == 32'd0) |=> (flag_z && !flag_n));

    assert_z_excludes_n_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z |-> !flag_n);

    assert_vc_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!flag_v && !flag_c));
endmodule

bind bfins_unit bfins_unit_chk u_chk (.*);

// File: tb/bfins_unit_test.sv
module bfins_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] dst_in = '0, ins_in = '0, width_reg = '0, off_reg = '0;
    logic [15:0] ext_in = '0;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_v, flag_c, valid;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string cur_tag = "R1";

    // Reference model state
    logic [31:0] m_res = '0;
    logic        m_n = 0, m_z = 0, m_valid = 0;

    always #10 clk = ~clk;   // 50 MHz

    bfins_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dst_in(dst_in),
        .ins_in(ins_in), .ext_in(ext_in), .width_reg(width_reg),
        .off_reg(off_reg), .result(result), .flag_n(flag_n),
        .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c), .valid(valid)
    );

    // Behavioural model: place insert bits one at a time
    task automatic ref_insert(input logic [31:0] d, input logic [31:0] s,
                              input logic [15:0] e, input logic [31:0] wr,
                              input logic [31:0] orr, output logic [31:0] r,
                              output logic n, output logic z);
        int w, o;
        w = e[5] ? int'(wr[4:0]) : int'(e[4:0]);
        if (w == 0) w = 32;
        o = e[11] ? int'(orr % 32) : int'(e[10:6]);
        r = d;
        z = 1'b1;
        for (int i = 0; i < w; i++) begin
            r[(64 - o - w + i) % 32] = s[i];
            if (s[i]) z = 1'b0;
        end
        n = s[w-1];
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_res = '0; m_n = 0; m_z = 0; m_valid = 0;
        end else begin
            m_valid = start;
            if (start) ref_insert(dst_in, ins_in, ext_in, width_reg, off_reg, m_res, m_n, m_z);
        end
    end

    task automatic compare();
        n_tests++;
        if (result !== m_res || flag_n !== m_n || flag_z !== m_z ||
            flag_v !== 1'b0 || flag_c !== 1'b0 || valid !== m_valid) begin
            n_fail++;
            $display("FAIL %s: actual res=%h n=%b z=%b v=%b c=%b valid=%b expected res=%h n=%b z=%b v=0 c=0 valid=%b",
                     cur_tag, result, flag_n, flag_z, flag_v, flag_c, valid,
                     m_res, m_n, m_z, m_valid);
        end
    endtask

    // One cycle: check the outputs of the previous cycle, then drive new inputs
    task automatic step(input logic [31:0] d, input logic [31:0] s,
                        input logic [15:0] e, input logic [31:0] wr,
                        input logic [31:0] orr, input logic st, input string tag);
        @(negedge clk);
        compare();
        dst_in = d; ins_in = s; ext_in = e; width_reg = wr; off_reg = orr;
        start = st; cur_tag = tag;
    endtask

    function automatic logic [15:0] ext_imm(input int off, input int wid);
        return 16'((off & 31) << 6) | 16'(wid & 31);
    endfunction

    initial begin
        // R1: reset state, checked while reset is held
        repeat (3) step('1, '1, 16'h0FFF, '1, '1, 1'b1, "R1");
        rst_n = 1'b1;
        step('0, '0, '0, '0, '0, 1'b0, "R1");
        // R2: immediate width 8 at offset 4
        step(32'h1234_5678, 32'h0000_00C3, ext_imm(4, 8), '0, '0, 1'b1, "R2");
        // R2: width from register (low 5 bits = 3)
        step(32'hFFFF_0000, 32'h0000_0005, 16'h0020 | ext_imm(16, 9), 32'hFFFF_FFE3, '0, 1'b1, "R2");
        // R3: offset from register, 37 mod 32 = 5; upper ext bits set
        step(32'h0000_0000, 32'h0000_002D, 16'hF800 | ext_imm(0, 6), '0, 32'd37, 1'b1, "R3");
        // R4: non-wrapping at offset 0
        step(32'h0F0F_0F0F, 32'h0000_000A, ext_imm(0, 4), '0, '0, 1'b1, "R4");
        // R5: high insert bits ignored
        step(32'h0000_0000, 32'hFFFF_FFF5, ext_imm(10, 4), '0, '0, 1'b1, "R5");
        // R6: wrap, offset 28 width 8
        step(32'h0000_0000, 32'hFFFF_FFA5, ext_imm(28, 8), '0, '0, 1'b1, "R6");
        // R6: wrap with register offset and register width
        step(32'hDEAD_BEEF, 32'h0000_7E81, 16'h0820, 32'd17, 32'd25, 1'b1, "R6");
        // R7: outside bits preserved
        step(32'hFFFF_FFFF, 32'h0000_0000, ext_imm(12, 5), '0, '0, 1'b1, "R7");
        // R8: full width, immediate code 0
        step(32'h5555_5555, 32'h8000_0001, ext_imm(7, 0), '0, '0, 1'b1, "R8");
        // R8: full width from register value 32
        step(32'h5555_5555, 32'hC001_0003, 16'h0020 | ext_imm(31, 0), 32'd32, '0, 1'b1, "R8");
        // R9: top inserted bit set
        step(32'h0000_0000, 32'h0000_0004, ext_imm(2, 3), '0, '0, 1'b1, "R9");
        // R10: inserted bits zero, garbage above
        step(32'hFFFF_FFFF, 32'h0000_0100, ext_imm(30, 8), '0, '0, 1'b1, "R10");
        // R11: V and C after an operation with N set
        step(32'h1234_5678, 32'hFFFF_FFFF, ext_imm(0, 0), '0, '0, 1'b1, "R11");
        // R12: back-to-back starts then idle with changing inputs
        step(32'h0000_0000, 32'h0000_0001, ext_imm(31, 2), '0, '0, 1'b1, "R12");
        step(32'hAAAA_AAAA, 32'h0000_0003, ext_imm(5, 2), '0, '0, 1'b1, "R12");
        step(32'h1111_1111, 32'hFFFF_FFFF, ext_imm(1, 9), '0, '0, 1'b0, "R12");
        step(32'h2222_2222, 32'h0000_0000, ext_imm(9, 3), '0, '0, 1'b0, "R12");
        // Sweep of offsets and widths, covering wrap and non-wrap cases (R4, R6)
        for (int k = 0; k < 64; k++) begin
            step(32'h9E37_79B9 * (k + 1), 32'h7F4A_7C15 ^ (k * 32'h0101_0101),
                 ext_imm((k * 7) % 32, (k * 5 + 1) % 32), '0, '0, 1'b1,
                 ((k * 7) % 32 + ((k * 5 + 1) % 32 == 0 ? 32 : (k * 5 + 1) % 32) > 32) ? "R6" : "R4");
        end
        step('0, '0, '0, '0, '0, 1'b0, "R12");
        step('0, '0, '0, '0, '0, 1'b0, "R12");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule